// File: doc/BRIEF.md
# ATA Configuration Command Handler

This block is the device-side executor for the configuration commands of a parallel ATA target. The host-facing logic passes on writes to the Command, Features and Sector Count task-file registers as single-cycle strobes that share one byte of write data. The block drives the BSY, DRDY and ERR status bits, the ABRT bit of the Error register and the interrupt request line.

Two commands are understood. The set-multiple command (opcode 0xC6) checks a requested sectors-per-block value and keeps it. The set-features command (opcode 0xEF) selects a DMA transfer mode (feature 0x03) or an advanced power-management level (feature 0x05). The resulting settings are held on output ports for the transfer and power logic elsewhere in the device.

A command write seen while the block is idle is accepted. It takes a copy of the Features and Sector Count registers, and BSY then stays high for a fixed number of cycles. When that phase ends the settings are updated, BSY drops and an interrupt is raised. The interrupt stays up until the host reads Status.

Top module: `ataCfgHandler`

## Requirements
- R1: While reset is held and on the first cycle after it, bsy, err, abrt, intrq, multiEn and apmEn are 0, and multiCount, xferMode and apmLevel are 0. xferClass reads 0, which means no DMA mode has been chosen. One clock edge after reset is released, drdy becomes 1.
- R2: A command write accepted while bsy is 0 sets bsy at the next clock edge. bsy stays high for exactly BUSY_CYCLES cycles (default 3). At the edge where bsy clears, intrq goes to 1.
- R3: A command write made while bsy is 1 is ignored. The busy phase keeps its length, and the result is that of the command that was accepted.
- R4: A status read (statusRdEn) while idle clears intrq. Accepting a new command also clears intrq.
- R5: Opcode 0xC6 with a Sector Count of 2, 4, 8, 16 or 32 stores that count on multiCount and sets multiEn. err and abrt stay 0.
- R6: Opcode 0xC6 with a Sector Count of 0 or 1 clears multiEn and multiCount, and sets neither err nor abrt.
- R7: Opcode 0xC6 with any other Sector Count clears multiEn and multiCount and sets both err and abrt.
- R8: Opcode 0xEF with Features 0x03 selects a transfer mode. Sector Count bits [7:3]=00100 with bits [2:0] from 0 to 2 gives xferClass=1 (multiword DMA). Bits [7:3]=01000 with bits [2:0] from 0 to 4 gives xferClass=2 (Ultra DMA). In both cases xferMode takes bits [2:0].
- R9: Any other Sector Count under Features 0x03 sets err and abrt and leaves xferClass and xferMode unchanged.
- R10: Opcode 0xEF with Features 0x05 and a Sector Count from 0x01 to 0xFE sets apmEn and stores the value on apmLevel. apmStandby is 1 for levels from 0x01 to 0x7F and 0 for levels from 0x80 to 0xFE.
- R11: Features 0x05 with a Sector Count of 0x00 or 0xFF sets err and abrt and leaves apmEn and apmLevel unchanged.
- R12: Any other opcode, or opcode 0xEF with any other Features value, sets err and abrt and changes no setting.
- R13: Accepting a command clears err and abrt. While bsy is high, err stays 0 and no setting output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe for the Command register |
| featWrEn | input | 1 | Write strobe for the Features register |
| cntWrEn | input | 1 | Write strobe for the Sector Count register |
| wrData | input | 8 | Write data shared by the three strobes |
| statusRdEn | input | 1 | Host read of Status; acknowledges the interrupt |
| bsy | output | 1 | Status BSY |
| drdy | output | 1 | Status DRDY |
| err | output | 1 | Status ERR |
| abrt | output | 1 | Error register ABRT bit |
| intrq | output | 1 | Interrupt request |
| multiEn | output | 1 | Multiple-sector read/write enabled |
| multiCount | output | 6 | Stored sectors per block |
| xferClass | output | 2 | 0 none, 1 multiword DMA, 2 Ultra DMA |
| xferMode | output | 3 | Mode number within the selected class |
| apmEn | output | 1 | Advanced power management enabled |
| apmLevel | output | 8 | Stored power-management level |
| apmStandby | output | 1 | Level allows standby (below 0x80) |

## Verification
A bad busy counter shows up as a BSY phase of the wrong length, measured in cycles from the accepting edge. It also shows up as a command written during busy that restarts or aborts the phase, which is visible one cycle after the intrusion as a longer phase or a raised err. A wrong decode or a wrongly held setting is seen at the completing edge. It shows either as a changed output where the command should have been refused, or as an err/abrt pair that disagrees with the command class. Outputs are also compared on every busy cycle, so an early or partial update is caught in the cycle it happens.

// File: rtl/ataCfgPkg.sv
package ataCfgPkg;

  localparam logic [7:0] OP_SET_MULTI = 8'hC6;
  localparam logic [7:0] OP_SET_FEAT  = 8'hEF;
  localparam logic [7:0] FEAT_XFER    = 8'h03;
  localparam logic [7:0] FEAT_APM     = 8'h05;
  localparam logic [4:0] XFER_TAG_MW  = 5'b00100;
  localparam logic [4:0] XFER_TAG_UD  = 5'b01000;

  typedef enum logic [1:0] {
    XFER_NONE  = 2'd0,
    XFER_MWDMA = 2'd1,
    XFER_UDMA  = 2'd2
  } xferClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // command taken this cycle
    logic busy;     // busy phase in progress
    logic commit;   // last busy cycle: apply the result
  } ctrlStrobe_t;

endpackage

// File: rtl/ataCfgCtrl.sv
module ataCfgCtrl
  import ataCfgPkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic        statusRdEn,
  output ctrlStrobe_t strobe,
  output logic        bsy,
  output logic        drdy,
  output logic        intrq
);

  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  logic             commit;

  assign accept = cmdWrEn && !bsy;
  assign commit = bsy && (busyCnt == '0);

  always_comb begin
    strobe.accept = accept;
    strobe.busy   = bsy;
    strobe.commit = commit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsy     <= 1'b0;
      busyCnt <= '0;
      intrq   <= 1'b0;
      drdy    <= 1'b0;
    end else begin
      drdy <= 1'b1;
      if (accept) begin
        bsy     <= 1'b1;
        busyCnt <= CNT_LOAD;
        intrq   <= 1'b0;
      end else if (commit) begin
        bsy   <= 1'b0;
        intrq <= 1'b1;
      end else begin
        if (bsy) busyCnt <= busyCnt - 1'b1;
        if (statusRdEn) intrq <= 1'b0;
      end
    end
  end

  // R2: an idle command write starts the busy phase
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !bsy) |=> bsy);

  // R2: the interrupt is up in the cycle busy ends
  p_irq_on_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bsy) |-> intrq);

  // R3: a busy-time write does not reload the counter
  p_no_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bsy && !commit) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R4: a status read while idle drops the request
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdEn && !commit) |=> !intrq);

endmodule

// File: rtl/ataCfgDatapath.sv
module ataCfgDatapath
  import ataCfgPkg::*;
#(
  parameter int MAX_BLOCK_LOG2 = 5,
  parameter int MAX_MW_MODE    = 2,
  parameter int MAX_UDMA_MODE  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    featWrEn,
  input  logic                    cntWrEn,
  input  logic [7:0]              wrData,
  input  ctrlStrobe_t             strobe,
  output logic                    err,
  output logic                    abrt,
  output logic                    multiEn,
  output logic [MAX_BLOCK_LOG2:0] multiCount,
  output xferClass_e              xferClass,
  output logic [2:0]              xferMode,
  output logic                    apmEn,
  output logic [7:0]              apmLevel,
  output logic                    apmStandby
);

  localparam int CNT_W = MAX_BLOCK_LOG2 + 1;

  logic [7:0] featReg, cntReg;
  logic [7:0] cmdSnap, featSnap, cntSnap;

  // supported block sizes: 2^1 .. 2^MAX_BLOCK_LOG2
  logic [MAX_BLOCK_LOG2:1] blockHit;
  logic                    blockOk;
  for (genvar g = 1; g <= MAX_BLOCK_LOG2; g++) begin : gBlock
    assign blockHit[g] = (cntSnap == 8'(1 << g));
  end
  assign blockOk = |blockHit;

  logic             nMultiEn, nApmEn, badCmd;
  logic [CNT_W-1:0] nMultiCount;
  xferClass_e       nXferClass;
  logic [2:0]       nXferMode;
  logic [7:0]       nApmLevel;

  always_comb begin
    nMultiEn    = multiEn;
    nMultiCount = multiCount;
    nXferClass  = xferClass;
    nXferMode   = xferMode;
    nApmEn      = apmEn;
    nApmLevel   = apmLevel;
    badCmd      = 1'b0;
    case (cmdSnap)
      OP_SET_MULTI: begin
        if (blockOk) begin
          nMultiEn    = 1'b1;
          nMultiCount = CNT_W'(cntSnap);
        end else begin
          nMultiEn    = 1'b0;
          nMultiCount = '0;
          badCmd      = (cntSnap > 8'd1);
        end
      end
      OP_SET_FEAT: begin
        case (featSnap)
          FEAT_XFER: begin
            if (cntSnap[7:3] == XFER_TAG_MW && cntSnap[2:0] <= 3'(MAX_MW_MODE)) begin
              nXferClass = XFER_MWDMA;
              nXferMode  = cntSnap[2:0];
            end else if (cntSnap[7:3] == XFER_TAG_UD && cntSnap[2:0] <= 3'(MAX_UDMA_MODE)) begin
              nXferClass = XFER_UDMA;
              nXferMode  = cntSnap[2:0];
            end else begin
              badCmd = 1'b1;
            end
          end
          FEAT_APM: begin
            if (cntSnap != 8'h00 && cntSnap != 8'hFF) begin
              nApmEn    = 1'b1;
              nApmLevel = cntSnap;
            end else begin
              badCmd = 1'b1;
            end
          end
          default: badCmd = 1'b1;
        endcase
      end
      default: badCmd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featReg    <= '0;
      cntReg     <= '0;
      cmdSnap    <= '0;
      featSnap   <= '0;
      cntSnap    <= '0;
      err        <= 1'b0;
      abrt       <= 1'b0;
      multiEn    <= 1'b0;
      multiCount <= '0;
      xferClass  <= XFER_NONE;
      xferMode   <= '0;
      apmEn      <= 1'b0;
      apmLevel   <= '0;
    end else begin
      if (featWrEn) featReg <= wrData;
      if (cntWrEn)  cntReg  <= wrData;
      if (strobe.accept) begin
        cmdSnap  <= wrData;
        featSnap <= featReg;
        cntSnap  <= cntReg;
        err      <= 1'b0;
        abrt     <= 1'b0;
      end else if (strobe.commit) begin
        err        <= badCmd;
        abrt       <= badCmd;
        multiEn    <= nMultiEn;
        multiCount <= nMultiCount;
        xferClass  <= nXferClass;
        xferMode   <= nXferMode;
        apmEn      <= nApmEn;
        apmLevel   <= nApmLevel;
      end
    end
  end

  assign apmStandby = apmEn && (apmLevel < 8'h80);

  // R7: an abort always carries the error bit
  p_abrt_with_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    abrt |-> err);

  // R5: an enabled multiple count is a supported power of two
  p_multi_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    multiEn |-> ($countones(multiCount) == 1 && !multiCount[0]));

  // R10: a stored level is never a reserved code
  p_apm_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    apmEn |-> (apmLevel != 8'h00 && apmLevel != 8'hFF));

  // R13: settings hold during the busy phase
  p_hold_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !strobe.commit) |=>
      $stable({multiEn, multiCount, xferClass, xferMode, apmEn, apmLevel}));

  // R13: acceptance clears the error flags
  p_err_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> (!err && !abrt));

endmodule

// File: rtl/ataCfgHandler.sv
module ataCfgHandler
  import ataCfgPkg::*;
#(
  parameter int BUSY_CYCLES    = 3,
  parameter int MAX_BLOCK_LOG2 = 5,
  parameter int MAX_MW_MODE    = 2,
  parameter int MAX_UDMA_MODE  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdWrEn,
  input  logic                    featWrEn,
  input  logic                    cntWrEn,
  input  logic [7:0]              wrData,
  input  logic                    statusRdEn,
  output logic                    bsy,
  output logic                    drdy,
  output logic                    err,
  output logic                    abrt,
  output logic                    intrq,
  output logic                    multiEn,
  output logic [MAX_BLOCK_LOG2:0] multiCount,
  output logic [1:0]              xferClass,
  output logic [2:0]              xferMode,
  output logic                    apmEn,
  output logic [7:0]              apmLevel,
  output logic                    apmStandby
);

  ctrlStrobe_t strobe;
  xferClass_e  xferClassInt;

  ataCfgCtrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .statusRdEn (statusRdEn),
    .strobe     (strobe),
    .bsy        (bsy),
    .drdy       (drdy),
    .intrq      (intrq)
  );

  ataCfgDatapath #(
    .MAX_BLOCK_LOG2 (MAX_BLOCK_LOG2),
    .MAX_MW_MODE    (MAX_MW_MODE),
    .MAX_UDMA_MODE  (MAX_UDMA_MODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .featWrEn   (featWrEn),
    .cntWrEn    (cntWrEn),
    .wrData     (wrData),
    .strobe     (strobe),
    .err        (err),
    .abrt       (abrt),
    .multiEn    (multiEn),
    .multiCount (multiCount),
    .xferClass  (xferClassInt),
    .xferMode   (xferMode),
    .apmEn      (apmEn),
    .apmLevel   (apmLevel),
    .apmStandby (apmStandby)
  );

  assign xferClass = xferClassInt;

endmodule

// File: tb/ataCfgHandler_bench.sv
`timescale 1ns/1ps
module ataCfgHandler_bench;

  localparam int BUSY = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cmdWrEn, featWrEn, cntWrEn, statusRdEn;
  logic [7:0] wrData;
  logic bsy, drdy, err, abrt, intrq, multiEn, apmEn, apmStandby;
  logic [5:0] multiCount;
  logic [1:0] xferClass;
  logic [2:0] xferMode;
  logic [7:0] apmLevel;

  ataCfgHandler u_ataCfgHandler (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .featWrEn(featWrEn),
    .cntWrEn(cntWrEn), .wrData(wrData), .statusRdEn(statusRdEn),
    .bsy(bsy), .drdy(drdy), .err(err), .abrt(abrt), .intrq(intrq),
    .multiEn(multiEn), .multiCount(multiCount), .xferClass(xferClass),
    .xferMode(xferMode), .apmEn(apmEn), .apmLevel(apmLevel),
    .apmStandby(apmStandby)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int mEn = 0, mCnt = 0, mCls = 0, mMode = 0, mApm = 0, mLvl = 0, mBad = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isBlock(int c);
    return (c == 2 || c == 4 || c == 8 || c == 16 || c == 32);
  endfunction

  function automatic string reqOf(int op, int ft, int c);
    if (op == 'hC6) return isBlock(c) ? "R5" : (c <= 1 ? "R6" : "R7");
    if (op != 'hEF) return "R12";
    if (ft == 3) return ((c >= 'h20 && c <= 'h22) || (c >= 'h40 && c <= 'h44)) ? "R8" : "R9";
    if (ft == 5) return (c == 0 || c == 'hFF) ? "R11" : "R10";
    return "R12";
  endfunction

  task automatic model(int op, int ft, int c);
    mBad = 0;
    if (op == 'hC6) begin
      if (isBlock(c)) begin mEn = 1; mCnt = c; end
      else begin mEn = 0; mCnt = 0; mBad = (c > 1); end
    end else if (op == 'hEF && ft == 3) begin
      if (c >= 'h20 && c <= 'h22) begin mCls = 1; mMode = c - 'h20; end
      else if (c >= 'h40 && c <= 'h44) begin mCls = 2; mMode = c - 'h40; end
      else mBad = 1;
    end else if (op == 'hEF && ft == 5) begin
      if (c != 0 && c != 'hFF) begin mApm = 1; mLvl = c; end
      else mBad = 1;
    end else mBad = 1;
  endtask

  task automatic checkSettings(string req);
    chk(req, "multiEn", int'(multiEn), mEn);
    chk(req, "multiCount", int'(multiCount), mCnt);
    chk(req, "xferClass", int'(xferClass), mCls);
    chk(req, "xferMode", int'(xferMode), mMode);
    chk(req, "apmEn", int'(apmEn), mApm);
    chk(req, "apmLevel", int'(apmLevel), mLvl);
    chk(req, "apmStandby", int'(apmStandby), int'(mApm == 1 && mLvl < 'h80));
  endtask

  task automatic issue(int op, int ft, int c, bit intrude, bit ackAfter);
    int busyN;
    string req;
    req = reqOf(op, ft, c);
    @(negedge clk); cntWrEn = 1'b1; wrData = 8'(c);
    @(negedge clk); cntWrEn = 1'b0; featWrEn = 1'b1; wrData = 8'(ft);
    @(negedge clk); featWrEn = 1'b0; cmdWrEn = 1'b1; wrData = 8'(op);
    @(negedge clk); cmdWrEn = 1'b0;
    chk("R2", "bsy after accept", int'(bsy), 1);
    chk("R4", "intrq cleared by accept", int'(intrq), 0);
    busyN = 0;
    while (bsy && busyN < 40) begin
      busyN++;
      chk("R13", "err during busy", int'(err), 0);
      checkSettings("R13");
      if (intrude && busyN == 1) begin cmdWrEn = 1'b1; wrData = 8'h00; end
      @(negedge clk);
      cmdWrEn = 1'b0;
    end
    chk(intrude ? "R3" : "R2", "busy length", busyN, BUSY);
    chk("R2", "intrq at done", int'(intrq), 1);
    model(op, ft, c);
    chk(req, "err", int'(err), mBad);
    chk(req, "abrt", int'(abrt), mBad);
    checkSettings(req);
    if (ackAfter) begin
      statusRdEn = 1'b1;
      @(negedge clk); statusRdEn = 1'b0;
      chk("R4", "intrq after status read", int'(intrq), 0);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  localparam int NPICK = 20;
  int picks [NPICK] = '{0, 1, 2, 4, 8, 16, 32, 3, 64, 'h20, 'h22, 'h23,
                        'h40, 'h44, 'h45, 'h00, 'hFF, 'h80, 'h7F, 'hFE};

  initial begin
    rstN = 1'b0; cmdWrEn = 1'b0; featWrEn = 1'b0; cntWrEn = 1'b0;
    statusRdEn = 1'b0; wrData = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "bsy", int'(bsy), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "intrq", int'(intrq), 0);
    chk("R1", "drdy in reset", int'(drdy), 0);
    checkSettings("R1");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "drdy after reset", int'(drdy), 1);

    // directed corners
    issue('hC6, 0, 16, 0, 1);      // R5
    issue('hC6, 0, 32, 0, 1);      // R5 largest
    issue('hC6, 0, 1, 0, 1);       // R6
    issue('hC6, 0, 8, 0, 1);       // R5
    issue('hC6, 0, 0, 0, 1);       // R6
    issue('hC6, 0, 8, 0, 1);
    issue('hC6, 0, 6, 0, 1);       // R7
    issue('hEF, 3, 'h22, 0, 1);    // R8 multiword
    issue('hEF, 3, 'h44, 0, 1);    // R8 ultra
    issue('hEF, 3, 'h45, 0, 1);    // R9
    issue('hEF, 3, 'h23, 0, 1);    // R9
    issue('hEF, 5, 'h7F, 0, 1);    // R10 with standby
    issue('hEF, 5, 'h80, 0, 1);    // R10 without standby
    issue('hEF, 5, 'hFF, 0, 1);    // R11
    issue('hEF, 5, 'h00, 0, 1);    // R11
    issue('hEF, 'h02, 'h10, 0, 1); // R12 unknown feature
    issue('h20, 0, 4, 0, 1);       // R12 unknown opcode
    issue('hC6, 0, 4, 1, 0);       // R3 intrusion, leave intrq pending
    issue('hEF, 3, 'h41, 1, 1);    // R4 accept clears pending intrq

    // constrained random
    for (int i = 0; i < 200; i++) begin
      int op, ft, c, sel;
      sel = int'($urandom % 8);
      op  = (sel < 3) ? 'hC6 : (sel < 6) ? 'hEF : int'($urandom % 256);
      sel = int'($urandom % 4);
      ft  = (sel < 2) ? 3 : (sel == 2) ? 5 : int'($urandom % 256);
      c   = ($urandom % 3 == 0) ? int'($urandom % 256) : picks[$urandom % NPICK];
      issue(op, ft, c, ($urandom % 5 == 0), 1);
    end
    finishRun();
  end

endmodule